// File: doc/BRIEF.md
# Circular frame-address queue manager

The block keeps four circular queues of 32-bit frame addresses inside one memory window that starts on a 1 MiB boundary. The four queues are inbound free, inbound post, outbound free and outbound post, with queue numbers 0, 1, 2 and 3. They sit back to back, and each one is `size_code << STRIDE_SHIFT` bytes long. The default stride unit is 2048 bytes. The block stores each head and tail pointer as an offset inside the window. It advances the pointers by one 4-byte word per entry and wraps them inside their own region. It tells an empty queue from a full one and raises the post-not-empty and overflow flags. The entries themselves are held in an internal synchronous word RAM.

All accesses share one request channel, and the block accepts one request per cycle. A request is a 4-bit opcode, a queue number and a 32-bit data word. Four host port operations map fixed pops and pushes onto the queues. Local push and local pop operations reach any queue, and two opcodes read back a pointer. Two more opcodes write the control register and initialise the window. Every request gets a registered response one cycle later, made of a valid strobe, an ok bit and a data word.

Top module: `mfa_queue_mgr`

## Requirements
- R1: Opcode 1 (init) takes the base from data[31:20] and latches the held size code. It presets every queue pointer and clears both overflow flags. It is refused (ok=0, base and pointers unchanged) when data[19:0] is not zero or when the held size code is 0.
- R2: Queue q starts at offset q × stride, where stride = size_code << STRIDE_SHIFT. After an accepted init, head and tail of every queue equal its start. Opcode 8 returns {base[31:20], head offset} of queue req_q_i, and opcode 9 returns the same for the tail. Both return ok=1.
- R3: Opcode 0 writes the control register: data[0] is enable and data[5:1] is the size code. A new size code takes effect at the next accepted init. While enable is 0, or before any accepted init, pops return 0xFFFFFFFF with ok=0 and pushes change nothing and return ok=0.
- R4: A pointer advances by 4 for each entry. When the advanced value reaches the end of its region, it wraps to the region's start.
- R5: A queue is empty when head equals tail. A pop from an empty queue returns 0xFFFFFFFF with ok=0 and leaves the tail unchanged.
- R6: A push is refused (ok=0, nothing stored) when the advanced head would equal the tail, so a region of N words holds at most N−1 entries.
- R7: Pops return the pushed words in push order. A local push (opcode 6) or local pop (opcode 7) acts on queue req_q_i.
- R8: Host port mapping. Opcode 2 pops the inbound free queue and opcode 3 pushes the inbound post queue. Opcode 4 pops the outbound post queue and opcode 5 pushes the outbound free queue.
- R9: inpost_irq_o is 1 exactly while the inbound post queue is not empty. outpost_irq_o is 1 exactly while the outbound post queue is not empty.
- R10: A refused opcode-3 push sets inpost_ovf_o, and a refused opcode-5 push sets outfree_ovf_o. Each flag stays set until an accepted init. Refused local pushes set neither flag.
- R11: rsp_valid_o is high in the cycle after each cycle in which req_valid_i is high, and low otherwise.
- R12: After reset the block is disabled and unconfigured, every pointer is zero, and all flags and rsp_valid_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| req_op_i | input | 4 | Opcode (0 ctrl, 1 init, 2–5 host port, 6 local push, 7 local pop, 8 head read, 9 tail read) |
| req_q_i | input | 2 | Queue number for opcodes 6–9 |
| req_data_i | input | ADDR_W | Control word, base, or entry to push |
| rsp_valid_o | output | 1 | Response strobe, one cycle after the request |
| rsp_ok_o | output | 1 | Request accepted |
| rsp_data_o | output | ADDR_W | Popped entry, sentinel, pointer value, or zero |
| inpost_irq_o | output | 1 | Inbound post queue not empty |
| outpost_irq_o | output | 1 | Outbound post queue not empty |
| inpost_ovf_o | output | 1 | Sticky inbound post overflow |
| outfree_ovf_o | output | 1 | Sticky outbound free overflow |

## Verification
Directed sequences run on a size-1 region of four words. Filling the inbound post queue to three entries and pushing once more separates the one-slot-empty full rule from a plain head-equals-tail check. A fourth pop then separates the empty sentinel from stale RAM data. A further push after the drain shows the wrap of the head back to its region start, as opposed to running into the next queue. Random mixes of all opcodes follow, with occasional size changes, rejected inits and disable phases. They tell apart a size code that is latched at init from one that is applied at once, and host-port overflow from local refusals.

// File: rtl/mfa_pkg.sv
package mfa_pkg;
  localparam int NQ = 4;
  localparam logic [1:0] Q_INFREE  = 2'd0;
  localparam logic [1:0] Q_INPOST  = 2'd1;
  localparam logic [1:0] Q_OUTFREE = 2'd2;
  localparam logic [1:0] Q_OUTPOST = 2'd3;

  typedef enum logic [3:0] {
    OP_CTRL     = 4'd0,
    OP_INIT     = 4'd1,
    OP_HIN_RD   = 4'd2,
    OP_HIN_WR   = 4'd3,
    OP_HOUT_RD  = 4'd4,
    OP_HOUT_WR  = 4'd5,
    OP_LPUSH    = 4'd6,
    OP_LPOP     = 4'd7,
    OP_PHEAD    = 4'd8,
    OP_PTAIL    = 4'd9
  } mfa_op_e;

  typedef struct packed {
    logic       push;
    logic       pop;
    logic [1:0] q;
    logic       host_wr;
    logic       rd_ptr;
    logic       rd_tail;
    logic       ctrl;
    logic       init;
  } op_dec_t;

  typedef enum logic [1:0] {
    RSP_ZERO = 2'd0,
    RSP_RAM  = 2'd1,
    RSP_ONES = 2'd2,
    RSP_REG  = 2'd3
  } rsp_kind_e;
endpackage

// File: rtl/mfa_op_decode.sv
module mfa_op_decode
  import mfa_pkg::*;
(
  input  logic [3:0] op_i,
  input  logic [1:0] q_i,
  output op_dec_t    dec_o
);
  always_comb begin
    dec_o = '0;
    unique case (mfa_op_e'(op_i))
      OP_CTRL:    dec_o.ctrl = 1'b1;
      OP_INIT:    dec_o.init = 1'b1;
      OP_HIN_RD:  begin dec_o.pop  = 1'b1; dec_o.q = Q_INFREE;  end
      OP_HIN_WR:  begin dec_o.push = 1'b1; dec_o.q = Q_INPOST;  dec_o.host_wr = 1'b1; end
      OP_HOUT_RD: begin dec_o.pop  = 1'b1; dec_o.q = Q_OUTPOST; end
      OP_HOUT_WR: begin dec_o.push = 1'b1; dec_o.q = Q_OUTFREE; dec_o.host_wr = 1'b1; end
      OP_LPUSH:   begin dec_o.push = 1'b1; dec_o.q = q_i; end
      OP_LPOP:    begin dec_o.pop  = 1'b1; dec_o.q = q_i; end
      OP_PHEAD:   begin dec_o.rd_ptr = 1'b1; dec_o.q = q_i; end
      OP_PTAIL:   begin dec_o.rd_ptr = 1'b1; dec_o.rd_tail = 1'b1; dec_o.q = q_i; end
      default:    dec_o = '0;
    endcase
  end
endmodule

// File: rtl/mfa_qptr.sv
module mfa_qptr #(
  parameter int OFF_W = 20,
  parameter int QIDX  = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_i,
  input  logic             init_i,
  input  logic [OFF_W-1:0] stride_i,
  input  logic [OFF_W-1:0] new_stride_i,
  input  logic             push_i,
  input  logic             pop_i,
  output logic [OFF_W-1:0] head_o,
  output logic [OFF_W-1:0] tail_o,
  output logic             empty_o,
  output logic             can_push_o
);
  logic [OFF_W-1:0] start, endp, new_start;
  logic [OFF_W-1:0] head_q, tail_q, head_inc, tail_inc, head_nx, tail_nx;

  assign start     = stride_i * OFF_W'(QIDX);
  assign endp      = start + stride_i;
  assign new_start = new_stride_i * OFF_W'(QIDX);

  assign head_inc = head_q + OFF_W'(4);
  assign tail_inc = tail_q + OFF_W'(4);
  assign head_nx  = (head_inc == endp) ? start : head_inc;
  assign tail_nx  = (tail_inc == endp) ? start : tail_inc;

  assign empty_o    = (head_q == tail_q);
  assign can_push_o = (head_nx != tail_q);
  assign head_o     = head_q;
  assign tail_o     = tail_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
    end else if (init_i) begin
      head_q <= new_start;
      tail_q <= new_start;
    end else begin
      if (push_i) head_q <= head_nx;
      if (pop_i)  tail_q <= tail_nx;
    end
  end

  assert_init_preset_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> (head_q == start) && (tail_q == start));

  assert_ptr_in_region_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_i |-> (head_q >= start) && (head_q < endp) && (tail_q >= start) && (tail_q < endp));

  assert_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && !init_i |=> (head_q != tail_q));

  assert_pop_nonempty_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> (head_q != tail_q));
endmodule

// File: rtl/mfa_word_ram.sv
module mfa_word_ram #(
  parameter int AW = 11,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    if (re_i) rdata_q <= mem[raddr_i];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/mfa_queue_mgr.sv
module mfa_queue_mgr
  import mfa_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int WIN_BITS     = 20,
  parameter int SZW          = 5,
  parameter int STRIDE_SHIFT = 11,
  parameter int RAM_AW       = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [3:0]        req_op_i,
  input  logic [1:0]        req_q_i,
  input  logic [ADDR_W-1:0] req_data_i,
  output logic              rsp_valid_o,
  output logic              rsp_ok_o,
  output logic [ADDR_W-1:0] rsp_data_o,
  output logic              inpost_irq_o,
  output logic              outpost_irq_o,
  output logic              inpost_ovf_o,
  output logic              outfree_ovf_o
);
  localparam int OFF_W  = WIN_BITS;
  localparam int BASE_W = ADDR_W - WIN_BITS;

  op_dec_t dec;

  logic              ctrl_en_q, cfg_q;
  logic [SZW-1:0]    ctrl_size_q, act_size_q;
  logic [BASE_W-1:0] base_q;
  logic              ip_ovf_q, of_ovf_q;
  logic              rsp_valid_q, rsp_ok_q;
  rsp_kind_e         rsp_kind_q;
  logic [ADDR_W-1:0] rsp_reg_q;

  logic [OFF_W-1:0] stride, new_stride;
  logic [OFF_W-1:0] head [NQ];
  logic [OFF_W-1:0] tail [NQ];
  logic [NQ-1:0]    empty, can_push, q_push, q_pop;
  logic             run, init_ok, sel_empty, sel_can_push;
  logic             push_go, pop_go, push_ref;
  logic [OFF_W-1:0] ptr_val;
  logic [ADDR_W-1:0] ram_rdata;

  mfa_op_decode u_dec (
    .op_i  (req_op_i),
    .q_i   (req_q_i),
    .dec_o (dec)
  );

  assign stride     = OFF_W'(act_size_q) << STRIDE_SHIFT;
  assign new_stride = OFF_W'(ctrl_size_q) << STRIDE_SHIFT;

  assign run     = req_valid_i && ctrl_en_q && cfg_q;
  assign init_ok = req_valid_i && dec.init &&
                   (req_data_i[WIN_BITS-1:0] == '0) && (ctrl_size_q != '0);

  assign sel_empty    = empty[dec.q];
  assign sel_can_push = can_push[dec.q];
  assign push_go  = run && dec.push && sel_can_push;
  assign push_ref = run && dec.push && !sel_can_push;
  assign pop_go   = run && dec.pop && !sel_empty;

  for (genvar g = 0; g < NQ; g++) begin : g_q
    assign q_push[g] = push_go && (dec.q == 2'(g));
    assign q_pop[g]  = pop_go  && (dec.q == 2'(g));
    mfa_qptr #(.OFF_W(OFF_W), .QIDX(g)) u_qptr (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .cfg_i        (cfg_q),
      .init_i       (init_ok),
      .stride_i     (stride),
      .new_stride_i (new_stride),
      .push_i       (q_push[g]),
      .pop_i        (q_pop[g]),
      .head_o       (head[g]),
      .tail_o       (tail[g]),
      .empty_o      (empty[g]),
      .can_push_o   (can_push[g])
    );
  end

  mfa_word_ram #(.AW(RAM_AW), .DW(ADDR_W)) u_ram (
    .clk_i   (clk_i),
    .we_i    (push_go),
    .waddr_i (head[dec.q][RAM_AW+1:2]),
    .wdata_i (req_data_i),
    .re_i    (pop_go),
    .raddr_i (tail[dec.q][RAM_AW+1:2]),
    .rdata_o (ram_rdata)
  );

  assign ptr_val = dec.rd_tail ? tail[dec.q] : head[dec.q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_en_q   <= 1'b0;
      ctrl_size_q <= '0;
      act_size_q  <= '0;
      cfg_q       <= 1'b0;
      base_q      <= '0;
      ip_ovf_q    <= 1'b0;
      of_ovf_q    <= 1'b0;
    end else begin
      if (req_valid_i && dec.ctrl) begin
        ctrl_en_q   <= req_data_i[0];
        ctrl_size_q <= req_data_i[SZW:1];
      end
      if (init_ok) begin
        base_q     <= req_data_i[ADDR_W-1:WIN_BITS];
        act_size_q <= ctrl_size_q;
        cfg_q      <= 1'b1;
        ip_ovf_q   <= 1'b0;
        of_ovf_q   <= 1'b0;
      end else if (push_ref && dec.host_wr) begin
        if (dec.q == Q_INPOST)  ip_ovf_q <= 1'b1;
        if (dec.q == Q_OUTFREE) of_ovf_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_ok_q    <= 1'b0;
      rsp_kind_q  <= RSP_ZERO;
      rsp_reg_q   <= '0;
    end else begin
      rsp_valid_q <= req_valid_i;
      rsp_ok_q    <= 1'b0;
      rsp_kind_q  <= RSP_ZERO;
      if (req_valid_i) begin
        if (dec.pop) begin
          rsp_ok_q   <= pop_go;
          rsp_kind_q <= pop_go ? RSP_RAM : RSP_ONES;
        end else if (dec.push) begin
          rsp_ok_q <= push_go;
        end else if (dec.rd_ptr) begin
          rsp_ok_q   <= 1'b1;
          rsp_kind_q <= RSP_REG;
          rsp_reg_q  <= {base_q, ptr_val};
        end else if (dec.ctrl) begin
          rsp_ok_q <= 1'b1;
        end else if (dec.init) begin
          rsp_ok_q <= init_ok;
        end
      end
    end
  end

  always_comb begin
    unique case (rsp_kind_q)
      RSP_RAM:  rsp_data_o = ram_rdata;
      RSP_ONES: rsp_data_o = '1;
      RSP_REG:  rsp_data_o = rsp_reg_q;
      default:  rsp_data_o = '0;
    endcase
  end

  assign rsp_valid_o   = rsp_valid_q;
  assign rsp_ok_o      = rsp_ok_q;
  assign inpost_irq_o  = !empty[Q_INPOST];
  assign outpost_irq_o = !empty[Q_OUTPOST];
  assign inpost_ovf_o  = ip_ovf_q;
  assign outfree_ovf_o = of_ovf_q;

  assert_rsp_latency_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  assert_rsp_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);

  assert_empty_sentinel_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && dec.pop && (!run || sel_empty) |=> (rsp_data_o == '1) && !rsp_ok_o);

  assert_misaligned_reject_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && dec.init && (req_data_i[WIN_BITS-1:0] != '0)
      |=> !rsp_ok_o && (base_q == $past(base_q)));

  assert_disabled_push_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && dec.push && !(ctrl_en_q && cfg_q) |=> !rsp_ok_o);

  assert_ovf_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ip_ovf_q && !init_ok |=> ip_ovf_q);
endmodule

// File: tb/mfa_queue_mgr_bench.sv
`timescale 1ns/1ps
module mfa_queue_mgr_bench;
  localparam int SH = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [3:0]  req_op_i = '0;
  logic [1:0]  req_q_i = '0;
  logic [31:0] req_data_i = '0;
  logic        rsp_valid_o, rsp_ok_o;
  logic [31:0] rsp_data_o;
  logic        inpost_irq_o, outpost_irq_o, inpost_ovf_o, outfree_ovf_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  mfa_queue_mgr #(.STRIDE_SHIFT(SH), .RAM_AW(8)) u_mfa_queue_mgr (
    .clk_i, .rst_ni, .req_valid_i, .req_op_i, .req_q_i, .req_data_i,
    .rsp_valid_o, .rsp_ok_o, .rsp_data_o,
    .inpost_irq_o, .outpost_irq_o, .inpost_ovf_o, .outfree_ovf_o
  );

  // reference state
  logic        m_en = 0, m_cfg = 0, m_ipo = 0, m_ofo = 0;
  logic [4:0]  m_size = 0, m_act = 0;
  logic [31:0] m_base = 0;
  logic [19:0] m_head [4];
  logic [19:0] m_tail [4];
  logic [31:0] mmem [256];
  logic [31:0] last_d;

  function automatic logic [19:0] m_stride();
    return 20'(m_act) << SH;
  endfunction
  function automatic logic [19:0] m_start(int q);
    return m_stride() * 20'(q);
  endfunction
  function automatic logic [19:0] m_adv(int q, logic [19:0] p);
    logic [19:0] s = p + 20'd4;
    return (s == m_start(q) + m_stride()) ? m_start(q) : s;
  endfunction
  function automatic string op_tag(logic [3:0] op);
    case (op)
      4'd0: return "R3";
      4'd1: return "R1";
      4'd2, 4'd3, 4'd4, 4'd5: return "R8";
      4'd6: return "R6";
      4'd7: return "R7";
      default: return "R2";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_op(logic [3:0] op, logic [1:0] q, logic [31:0] d);
    logic [31:0] ed = '0;
    logic        eok = 0;
    int qq;
    logic [19:0] nh;
    case (op)
      4'd0: begin m_en = d[0]; m_size = d[5:1]; eok = 1; end
      4'd1: if (d[19:0] == 0 && m_size != 0) begin
        m_base = {d[31:20], 20'h0}; m_act = m_size; m_cfg = 1;
        for (int i = 0; i < 4; i++) begin m_head[i] = m_start(i); m_tail[i] = m_start(i); end
        m_ipo = 0; m_ofo = 0; eok = 1;
      end
      4'd2, 4'd4, 4'd7: begin
        qq = (op == 4'd2) ? 0 : (op == 4'd4) ? 3 : int'(q);
        if (!(m_en && m_cfg) || m_head[qq] == m_tail[qq]) ed = '1;
        else begin
          ed = mmem[m_tail[qq][9:2]];
          m_tail[qq] = m_adv(qq, m_tail[qq]);
          eok = 1;
        end
      end
      4'd3, 4'd5, 4'd6: begin
        qq = (op == 4'd3) ? 1 : (op == 4'd5) ? 2 : int'(q);
        if (m_en && m_cfg) begin
          nh = m_adv(qq, m_head[qq]);
          if (nh == m_tail[qq]) begin
            if (op == 4'd3) m_ipo = 1;
            if (op == 4'd5) m_ofo = 1;
          end else begin
            mmem[m_head[qq][9:2]] = d;
            m_head[qq] = nh;
            eok = 1;
          end
        end
      end
      4'd8: begin eok = 1; ed = m_base | 32'(m_head[q]); end
      4'd9: begin eok = 1; ed = m_base | 32'(m_tail[q]); end
      default: ;
    endcase
    req_valid_i = 1; req_op_i = op; req_q_i = q; req_data_i = d;
    @(negedge clk_i);
    req_valid_i = 0;
    last_d = rsp_data_o;
    chk("R11 rsp_valid", 32'(rsp_valid_o), 32'd1);
    chk({op_tag(op), " ok"}, 32'(rsp_ok_o), 32'(eok));
    chk({op_tag(op), " data"}, rsp_data_o, ed);
    chk("R9 inpost_irq", 32'(inpost_irq_o), 32'(m_head[1] != m_tail[1]));
    chk("R9 outpost_irq", 32'(outpost_irq_o), 32'(m_head[3] != m_tail[3]));
    chk("R10 inpost_ovf", 32'(inpost_ovf_o), 32'(m_ipo));
    chk("R10 outfree_ovf", 32'(outfree_ovf_o), 32'(m_ofo));
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin m_head[i] = 0; m_tail[i] = 0; end
    for (int i = 0; i < 256; i++) mmem[i] = 0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk_i);
    chk("R12 rsp_valid", 32'(rsp_valid_o), 0);
    chk("R12 flags", {28'd0, inpost_irq_o, outpost_irq_o, inpost_ovf_o, outfree_ovf_o}, 0);
    rst_ni = 1;
    @(negedge clk_i);
    chk("R12 idle", 32'(rsp_valid_o), 0);

    do_op(4'd2, 0, 0);                       // unconfigured pop: R3
    do_op(4'd0, 0, 32'h3);                   // enable, size 1
    do_op(4'd1, 0, 32'h0034_5000);           // misaligned: R1
    do_op(4'd8, 0, 0);
    chk("R1 base kept", last_d, 32'h0);
    do_op(4'd1, 0, 32'h0030_0000);
    for (int q = 0; q < 4; q++) begin
      do_op(4'd8, 2'(q), 0);
      chk("R2 head start", last_d, 32'h0030_0000 + 32'(q * 16));
      do_op(4'd9, 2'(q), 0);
      chk("R2 tail start", last_d, 32'h0030_0000 + 32'(q * 16));
    end
    for (int k = 0; k < 4; k++) do_op(4'd3, 0, 32'hA0 + 32'(k));  // 4th refused: R6 R10
    chk("R10 inpost_ovf set", 32'(inpost_ovf_o), 1);
    for (int k = 0; k < 4; k++) begin
      do_op(4'd7, 2'd1, 0);
      chk(k < 3 ? "R7 order" : "R5 empty sentinel", last_d, k < 3 ? 32'hA0 + 32'(k) : 32'hFFFF_FFFF);
    end
    do_op(4'd9, 2'd1, 0);
    chk("R5 tail kept", last_d, 32'h0030_001C);
    do_op(4'd3, 0, 32'hB0);
    do_op(4'd8, 2'd1, 0);
    chk("R4 head wrap", last_d, 32'h0030_0010);
    do_op(4'd0, 0, 32'h2);                   // disable
    do_op(4'd5, 0, 32'hC0);
    do_op(4'd8, 2'd2, 0);
    chk("R3 push ignored", last_d, 32'h0030_0020);
    do_op(4'd0, 0, 32'h3);

    for (int n = 0; n < 3000; n++) begin
      int r = $urandom_range(0, 99);
      logic [31:0] d = $urandom;
      if (r < 2) do_op(4'd0, 0, {26'd0, 5'($urandom_range(0, 4)), ($urandom_range(0, 9) != 0)});
      else if (r < 4) do_op(4'd1, 0, ($urandom_range(0, 4) == 0) ? d : {d[31:20], 20'h0});
      else if (r < 12) do_op(4'(8 + $urandom_range(0, 1)), 2'($urandom_range(0, 3)), 0);
      else do_op(4'($urandom_range(2, 7)), 2'($urandom_range(0, 3)), d);
    end

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule